// File: doc/BRIEF.md
# Parallel Word Receive Synchronizer

This block sits at the receive end of a parallel point-to-point word bus. It runs directly on the word clock sent by the transmitter. On each edge of that clock it samples a 32-bit data word together with two active-low qualifiers: data-valid and sync. Accepted words leave on a valid output. Each word carries a start-of-frame tag and its index within the current frame or burst.

A mode input selects one of two ways of receiving. In unframed reception the sync line is ignored, and every word presented with data-valid asserted is taken. In framed reception the receiver must first see a sync. It then takes nothing until the first clock period in which data-valid is asserted without sync. Words that arrive before any sync are counted as drops.

When data-valid deasserts after at least one accepted word, the block reports the word count with a one-cycle done strobe. A sync that arrives during a frame also ends that frame and re-arms the receiver.

Top module: `fp_word_rx_sync`

## Requirements
- R1: After reset the output valid, start-of-frame, done strobe, frame size and drop count are all zero.
- R2: With `framed_i` low, every word sampled with `dvalid_ni` low appears unchanged on `out_data_o` with `out_valid_o` high two clock edges later. `out_sof_o` is 0, and `out_idx_o` counts 0,1,2,... within each burst. `sync_ni` has no effect.
- R3: With `framed_i` high and no sync seen since the last frame ended, a word with `dvalid_ni` low and `sync_ni` high is not output and increments `drop_cnt_o` by one.
- R4: A word sampled while `sync_ni` is low is never output in framed mode. The first later word with `dvalid_ni` low and `sync_ni` high is output with `out_sof_o`=1 and `out_idx_o`=0.
- R5: Each further word of a frame is output with `out_sof_o`=0 and `out_idx_o` one above the previous word's index.
- R6: When `dvalid_ni` is sampled high after one or more accepted words, `frame_done_o` is high for exactly one cycle and `frame_size_o` equals the number of accepted words. In framed mode a new sync is then needed before further words are accepted.
- R7: In framed mode, a sync sampled together with `dvalid_ni` low during a frame ends that frame with a done strobe and its size. The next valid word starts a new frame at index 0 with start-of-frame set.
- R8: `drop_cnt_o` only steps up by one and holds at all ones once it gets there.
- R9: In framed mode, any number of cycles with `dvalid_ni` high between a sync and the data leave the receiver armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock from the transmitter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| framed_i | input | 1 | 1 = framed reception, 0 = unframed |
| data_i | input | DATA_W | Word bus |
| dvalid_ni | input | 1 | Data-valid, active low |
| sync_ni | input | 1 | Frame sync, active low |
| out_valid_o | output | 1 | Accepted word present |
| out_data_o | output | DATA_W | Accepted word |
| out_sof_o | output | 1 | Word is first of a frame |
| out_idx_o | output | CNT_W | Word index in frame or burst |
| frame_done_o | output | 1 | One-cycle end-of-frame strobe |
| frame_size_o | output | CNT_W | Words in the frame just ended |
| drop_cnt_o | output | DROP_W | Saturating count of discarded words |

## Verification
The hardest case to reach from the ports is a sync that arrives in the middle of a live frame, while data-valid stays asserted. In that case the end of one frame and the arming of the next fall on the same clock. The stimulus sends a short framed burst and drives sync low on one word with data-valid still low. It then checks three things: the done strobe and size for the old frame in place of a word, and start-of-frame with index 0 on the very next word. Saturation of the drop counter is reached by streaming several hundred unsynchronised words in framed mode.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FRAME = 2'd2
  } wrf_state_e;
endpackage

// File: rtl/wrf_in_stage.sv
module wrf_in_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              framed_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dvalid_ni,
  input  logic              sync_ni,
  output logic              framed_o,
  output logic [DATA_W-1:0] data_o,
  output logic              dv_o,
  output logic              sync_o
);
  // single capture register on the transmitter clock; polarity normalised here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      framed_o <= 1'b0;
      data_o   <= '0;
      dv_o     <= 1'b0;
      sync_o   <= 1'b0;
    end else begin
      framed_o <= framed_i;
      data_o   <= data_i;
      dv_o     <= ~dvalid_ni;
      sync_o   <= ~sync_ni;
    end
  end
endmodule

// File: rtl/wrf_sat_cnt.sv
module wrf_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_o <= '0;
    else if (inc_i && q_o != MAX) q_o <= q_o + 1'b1;
  end

  a_r8_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != $past(q_o)) |-> (q_o == $past(q_o) + 1'b1));
  a_r8_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(q_o) == MAX) |-> (q_o == MAX));
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              framed_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dv_i,
  input  logic              sync_i,
  output logic              drop_inc_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic [CNT_W-1:0]  out_idx_o,
  output logic              frame_done_o,
  output logic [CNT_W-1:0]  frame_size_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  wrf_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept, sof, end_frame;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    accept     = 1'b0;
    sof        = 1'b0;
    end_frame  = 1'b0;
    drop_inc_o = 1'b0;
    if (!framed_i) begin
      state_d = ST_IDLE;
      if (dv_i)                accept    = 1'b1;
      else if (cnt_q != '0)    end_frame = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (sync_i)    state_d    = ST_ARMED;
          else if (dv_i) drop_inc_o = 1'b1;
        end
        ST_ARMED: begin
          cnt_d = '0;
          if (!sync_i && dv_i) begin
            accept  = 1'b1;
            sof     = 1'b1;
            state_d = ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (sync_i) begin
            end_frame = 1'b1;
            state_d   = ST_ARMED;
          end else if (!dv_i) begin
            end_frame = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            accept = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    if (accept)    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    if (end_frame) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      out_valid_o  <= 1'b0;
      out_data_o   <= '0;
      out_sof_o    <= 1'b0;
      out_idx_o    <= '0;
      frame_done_o <= 1'b0;
      frame_size_o <= '0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      out_valid_o  <= accept;
      out_sof_o    <= sof;
      frame_done_o <= end_frame;
      if (accept)    out_data_o   <= data_i;
      if (accept)    out_idx_o    <= cnt_q;
      if (end_frame) frame_size_o <= cnt_q;
    end
  end

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  a_r6_done_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !out_valid_o);
  a_r4_sof_index_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o) |-> (out_idx_o == '0));
  a_r5_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sof_o && $past(out_valid_o) && $past(out_idx_o) != CNT_MAX)
      |-> (out_idx_o == $past(out_idx_o) + 1'b1));
  a_r2_no_sof_unframed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(framed_i) && out_valid_o) |-> !out_sof_o);
endmodule

// File: rtl/fp_word_rx_sync.sv
module fp_word_rx_sync #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              framed_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dvalid_ni,
  input  logic              sync_ni,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic [CNT_W-1:0]  out_idx_o,
  output logic              frame_done_o,
  output logic [CNT_W-1:0]  frame_size_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              framed_q, dv_q, sync_q, drop_inc;
  logic [DATA_W-1:0] data_q;

  wrf_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .framed_i (framed_i),
    .data_i   (data_i),
    .dvalid_ni(dvalid_ni),
    .sync_ni  (sync_ni),
    .framed_o (framed_q),
    .data_o   (data_q),
    .dv_o     (dv_q),
    .sync_o   (sync_q)
  );

  wrf_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .framed_i    (framed_q),
    .data_i      (data_q),
    .dv_i        (dv_q),
    .sync_i      (sync_q),
    .drop_inc_o  (drop_inc),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .out_idx_o   (out_idx_o),
    .frame_done_o(frame_done_o),
    .frame_size_o(frame_size_o)
  );

  wrf_sat_cnt #(.W(DROP_W)) u_drop (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (drop_inc),
    .q_o   (drop_cnt_o)
  );
endmodule

// File: tb/fp_word_rx_sync_tb.sv
module fp_word_rx_sync_tb;
  localparam int DW = 32, CW = 16, DRW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          framed = 1'b0, dvalid_n = 1'b1, sync_n = 1'b1;
  logic [DW-1:0] data = '0;
  logic          o_valid, o_sof, o_done;
  logic [DW-1:0] o_data;
  logic [CW-1:0] o_idx, o_size;
  logic [DRW-1:0] o_drop;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fp_word_rx_sync #(.DATA_W(DW), .CNT_W(CW), .DROP_W(DRW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .framed_i(framed), .data_i(data),
    .dvalid_ni(dvalid_n), .sync_ni(sync_n), .out_valid_o(o_valid),
    .out_data_o(o_data), .out_sof_o(o_sof), .out_idx_o(o_idx),
    .frame_done_o(o_done), .frame_size_o(o_size), .drop_cnt_o(o_drop)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge; on return outputs reflect the stimulus of the previous call
  task automatic tick(input logic dvn, input logic syn, input logic [DW-1:0] d);
    dvalid_n = dvn; sync_n = syn; data = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic exp_word(input logic sof, input int idx, input logic [DW-1:0] d, input string tag);
    chk(o_valid == 1'b1, {tag, " valid"}, o_valid, 1);
    chk(o_data == d, {tag, " data"}, o_data, d);
    chk(o_sof == sof, {tag, " sof"}, o_sof, sof);
    chk(o_idx == CW'(idx), {tag, " idx"}, o_idx, idx);
  endtask

  task automatic exp_none(input int drop, input string tag);
    chk(o_valid == 1'b0, {tag, " no word"}, o_valid, 0);
    chk(o_drop == DRW'(drop), {tag, " drop"}, o_drop, drop);
  endtask

  task automatic exp_done(input int size, input string tag);
    chk(o_done == 1'b1, {tag, " done"}, o_done, 1);
    chk(o_size == CW'(size), {tag, " size"}, o_size, size);
  endtask

  task automatic t_reset;
    chk(!o_valid && !o_sof && !o_done, "R1 flags", {o_valid, o_sof, o_done}, 0);
    chk(o_size == '0, "R1 size", o_size, 0);
    chk(o_drop == '0, "R1 drop", o_drop, 0);
  endtask

  task automatic t_unframed;
    framed = 1'b0;
    tick(1, 1, 0);
    tick(0, 1, 32'hA000_0000);
    tick(0, 0, 32'hA000_0001);          // sync ignored in R2
    exp_word(0, 0, 32'hA000_0000, "R2 w0");
    tick(0, 1, 32'hA000_0002);
    exp_word(0, 1, 32'hA000_0001, "R2 w1");
    tick(0, 1, 32'hA000_0003);
    exp_word(0, 2, 32'hA000_0002, "R2 w2");
    tick(1, 1, 0);
    exp_word(0, 3, 32'hA000_0003, "R2 w3");
    tick(1, 1, 0);
    exp_done(4, "R6 unframed");
    tick(0, 1, 32'hB000_0000);
    chk(!o_done, "R6 one cycle", o_done, 0);
    tick(1, 1, 0);
    exp_word(0, 0, 32'hB000_0000, "R2 restart");
    tick(1, 1, 0);
    exp_done(1, "R6 burst1");
    exp_none(0, "R2");
  endtask

  task automatic t_no_sync;
    framed = 1'b1;
    tick(1, 1, 0);
    tick(0, 1, 32'h1);
    tick(0, 1, 32'h2);
    exp_none(1, "R3 a");
    tick(0, 1, 32'h3);
    exp_none(2, "R3 b");
    tick(1, 1, 0);
    exp_none(3, "R3 c");
  endtask

  task automatic t_frame;
    tick(0, 0, 32'hDEAD_0000);          // word with sync: not taken, not dropped
    tick(1, 1, 0);
    exp_none(3, "R4 sync word");
    tick(1, 1, 0);
    tick(1, 1, 0);
    exp_none(3, "R9 armed wait");
    tick(0, 1, 32'hC000_0000);
    tick(0, 1, 32'hC000_0001);
    exp_word(1, 0, 32'hC000_0000, "R4 first");
    tick(0, 1, 32'hC000_0002);
    exp_word(0, 1, 32'hC000_0001, "R5 second");
    tick(1, 1, 0);
    exp_word(0, 2, 32'hC000_0002, "R5 third");
    tick(1, 1, 0);
    exp_done(3, "R6 framed");
    tick(0, 1, 32'hEEEE_0000);
    chk(!o_done, "R6 one cycle framed", o_done, 0);
    tick(1, 1, 0);
    exp_none(4, "R6 needs sync");
  endtask

  task automatic t_resync;
    tick(1, 0, 0);
    tick(0, 1, 32'hD000_0000);
    tick(0, 1, 32'hD000_0001);
    exp_word(1, 0, 32'hD000_0000, "R7 a0");
    tick(0, 0, 32'hD000_00FF);          // sync with data-valid held low
    exp_word(0, 1, 32'hD000_0001, "R7 a1");
    tick(0, 1, 32'hD100_0000);
    exp_done(2, "R7 end");
    chk(!o_valid, "R7 sync word dropped from output", o_valid, 0);
    tick(1, 1, 0);
    exp_word(1, 0, 32'hD100_0000, "R7 b0");
    tick(1, 1, 0);
    exp_done(1, "R7 b end");
    exp_none(4, "R7");
  endtask

  task automatic t_drop_sat;
    for (int i = 0; i < 300; i++) tick(0, 1, 32'(i));
    tick(1, 1, 0);
    tick(1, 1, 0);
    exp_none(255, "R8 saturate");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_unframed;
    t_no_sync;
    t_frame;
    t_resync;
    t_drop_sat;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule